// File: doc/BRIEF.md
# Serial Flash Write-Enable Guard

This block is the instruction front end of a serial-flash slave on an SPI link, mode 0. It keeps the write-enable latch, the single bit that lets any array-modifying command through. While chip select is low it shifts in one 8-bit instruction. When chip select returns high, it acts on that instruction.

The set command arms the latch and the reset command disarms it. Four modifying instructions are let through only while the latch is armed and no earlier modification is still running. An accepted one produces a one-cycle strobe towards the memory back end, which later reports completion on a done input. That completion disarms the latch.

All SPI inputs are synchronised into the system clock domain. The serial output is never driven. Addressing, data transfer and the array itself lie outside this block.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After reset, `wel_o` and `mod_accept_o` are 0.
- R2: Opcode 0x06 (bits sampled MSB first on rising SCK while `cs_ni` is low), followed by `cs_ni` rising after exactly 8 SCK rises, sets `wel_o`.
- R3: Opcode 0x04, framed the same way, clears `wel_o`.
- R4: A frame whose SCK rise count is not exactly 8 (for example 7 or 9) has no effect on `wel_o`.
- R5: Any of the modifying opcodes 0x0A, 0x02, 0xDB or 0xD8, received while `wel_o` is 1 and no modification is pending, gives exactly one `mod_accept_o` pulse one cycle wide.
- R6: A modifying opcode received while `wel_o` is 0 gives no `mod_accept_o` pulse.
- R7: `op_done_i` high at a clock edge makes `wel_o` 0 after that edge and ends the pending modification.
- R8: The set (0x06) and clear (0x04) opcodes received between an accepted modification and its `op_done_i` are ignored, so `wel_o` keeps its value.
- R9: A modifying opcode received while a modification is pending gives no `mod_accept_o` pulse.
- R10: An opcode outside the six listed above leaves `wel_o` unchanged and gives no pulse.
- R11: `miso_oe_o` is always 0, so the serial output stays high-impedance.
- R12: The effect of a frame shows at the fourth rising clock edge after `cs_ni` rises; after the third edge, `wel_o` still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| mosi_i | input | 1 | SPI serial data in |
| miso_o | output | 1 | SPI serial data out (never enabled) |
| miso_oe_o | output | 1 | Output enable for miso_o, held 0 |
| op_done_i | input | 1 | Back end reports that the pending modification has completed |
| mod_accept_o | output | 1 | One-cycle strobe: modifying command accepted |
| wel_o | output | 1 | Write-enable latch state |

## Verification
Latch changes and the accept strobe appear on the fourth clock edge after chip select rises. Two of those edges are the synchroniser, one is edge detection with framing, and one is the latch register. The bench therefore waits eight cycles after each frame before it samples `wel_o` at a falling edge. The R12 check counts the edges one by one and samples at the falling edge after the third and after the fourth. A clear caused by `op_done_i` is due one edge later, so it is sampled at the next falling edge. Accept pulses are matched from a queue at falling edges, so a missing pulse, an extra pulse or a pulse wider than one cycle is reported.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;
  localparam int OP_W = 8;
  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_WREN = 8'h06;
  localparam op_t OP_WRDI = 8'h04;
  localparam op_t OP_PW   = 8'h0A;
  localparam op_t OP_PP   = 8'h02;
  localparam op_t OP_PE   = 8'hDB;
  localparam op_t OP_SE   = 8'hD8;

  typedef enum logic [1:0] {CMD_NONE, CMD_SET, CMD_CLR, CMD_MOD} cmd_e;

  function automatic cmd_e decode_op(op_t op);
    case (op)
      OP_WREN:                    return CMD_SET;
      OP_WRDI:                    return CMD_CLR;
      OP_PW, OP_PP, OP_PE, OP_SE: return CMD_MOD;
      default:                    return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_wel_sync.sv
module spi_wel_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_wel_shifter.sv
module spi_wel_shifter
  import spi_wel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic frame_vld_o,
  output op_t  frame_op_o
);
  localparam int CNT_MAX = OP_W + 1;           // saturates: "more than OP_W"
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] bit_cnt;
  op_t              shreg;
  logic             sck_rise, cs_rise;

  assign sck_rise = sck_i & ~sck_q & ~cs_n_i;
  assign cs_rise  = cs_n_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_n_i) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[OP_W-2:0], mosi_i};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_vld_o <= 1'b0;
      frame_op_o  <= '0;
    end else begin
      frame_vld_o <= cs_rise && (bit_cnt == CNT_W'(OP_W));
      frame_op_o  <= shreg;
    end
  end
endmodule

// File: rtl/spi_wel_latch.sv
module spi_wel_latch
  import spi_wel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_vld_i,
  input  op_t  frame_op_i,
  input  logic op_done_i,
  output logic wel_o,
  output logic accept_o
);
  cmd_e cmd;
  logic busy_q;

  assign cmd = frame_vld_i ? decode_op(frame_op_i) : CMD_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o    <= 1'b0;
      busy_q   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      if (op_done_i) begin
        wel_o  <= 1'b0;
        busy_q <= 1'b0;
      end else begin
        unique case (cmd)
          CMD_SET: if (!busy_q) wel_o <= 1'b1;
          CMD_CLR: if (!busy_q) wel_o <= 1'b0;
          CMD_MOD: if (wel_o && !busy_q) begin
            accept_o <= 1'b1;
            busy_q   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
  import spi_wel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o,
  input  logic op_done_i,
  output logic mod_accept_o,
  output logic wel_o
);
  logic [2:0] spi_sync;
  logic       frame_vld;
  op_t        frame_op;

  spi_wel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, mosi_i}),
    .q_o    (spi_sync)
  );

  spi_wel_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (spi_sync[2]),
    .sck_i       (spi_sync[1]),
    .mosi_i      (spi_sync[0]),
    .frame_vld_o (frame_vld),
    .frame_op_o  (frame_op)
  );

  spi_wel_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_op_i  (frame_op),
    .op_done_i   (op_done_i),
    .wel_o       (wel_o),
    .accept_o    (mod_accept_o)
  );

  // no read instructions handled here: output never driven
  assign miso_o    = 1'b0;
  assign miso_oe_o = 1'b0;
endmodule

// File: rtl/spi_wel_chk.sv
module spi_wel_chk
  import spi_wel_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic wel_o,
  input logic mod_accept_o,
  input logic miso_oe_o,
  input logic op_done_i,
  input logic frame_vld,
  input op_t  frame_op
);
  assert_oe_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o);

  assert_accept_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_accept_o |=> !mod_accept_o);

  assert_accept_needs_wel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_accept_o |-> $past(wel_o));

  assert_done_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |=> !wel_o);

  assert_set_by_wren_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_o) |-> $past(frame_vld && frame_op == OP_WREN));

  assert_clear_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_o) |-> $past(op_done_i || (frame_vld && frame_op == OP_WRDI)));
endmodule

bind spi_wel_ctrl spi_wel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wel_o        (wel_o),
  .mod_accept_o (mod_accept_o),
  .miso_oe_o    (miso_oe_o),
  .op_done_i    (op_done_i),
  .frame_vld    (frame_vld),
  .frame_op     (frame_op)
);

// File: tb/tb_spi_wel_ctrl.sv
`timescale 1ns/1ps
module tb_spi_wel_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, mosi = 1'b0, op_done = 1'b0;
  logic miso, miso_oe, mod_accept, wel;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] cur_op = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_wel_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .op_done_i(op_done),
    .mod_accept_o(mod_accept), .wel_o(wel)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] op, input int nbits);
    logic [15:0] pat;
    pat = {op, 8'h00};
    cs_ni = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = pat[15-i];
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
  endtask

  // driver: pushes the expected accept into the scoreboard
  task automatic send(input logic [7:0] op, input int nbits, input bit exp_acc);
    shift_bits(op, nbits);
    cur_op = op;
    if (exp_acc) exp_q.push_back(op);
    cs_ni = 1'b1;
    wait_clk(8);
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk(wel, 1'b0, "R7 wel after done");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && mod_accept) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R6/R9: actual=accept op %h expected=no accept", cur_op);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (e !== cur_op) begin
          n_bad++;
          $display("FAIL R5: actual=%h expected=%h", cur_op, e);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0] mods [4];
    mods = '{8'h0A, 8'h02, 8'hDB, 8'hD8};
    wait_clk(3);
    chk(wel, 1'b0, "R1 wel in reset");
    chk(mod_accept, 1'b0, "R1 accept in reset");
    rst_ni = 1'b1;
    wait_clk(3);
    chk(wel, 1'b0, "R1 wel after reset");
    chk(miso_oe, 1'b0, "R11 output enable");

    send(8'h06, 8, 0); chk(wel, 1'b1, "R2 set");
    send(8'h04, 8, 0); chk(wel, 1'b0, "R3 clear");
    send(8'h06, 7, 0); chk(wel, 1'b0, "R4 seven bits");
    send(8'h06, 9, 0); chk(wel, 1'b0, "R4 nine bits");
    send(8'h06, 8, 0);
    send(8'h04, 7, 0); chk(wel, 1'b1, "R4 short clear ignored");
    send(8'h05, 8, 0); chk(wel, 1'b1, "R10 unknown opcode");
    send(8'hFF, 8, 0); chk(wel, 1'b1, "R10 unknown opcode 2");

    send(8'h02, 8, 1); chk(wel, 1'b1, "R5 wel held until done");
    send(8'hD8, 8, 0);                       // R9 pending: no accept
    send(8'h04, 8, 0); chk(wel, 1'b1, "R8 clear while pending");
    done_pulse();
    send(8'h06, 8, 0); chk(wel, 1'b1, "R8 set after done");
    send(8'h04, 8, 0);

    for (int k = 0; k < 4; k++) begin
      send(8'h06, 8, 0);
      send(mods[k], 8, 1);
      done_pulse();
      send(mods[k], 8, 0);                   // R6 latch clear: no accept
      chk(wel, 1'b0, "R6 wel stays clear");
    end

    // R12: edge-exact latency
    shift_bits(8'h06, 8);
    cs_ni = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk(wel, 1'b0, "R12 before 4th edge");
    @(posedge clk);
    @(negedge clk); chk(wel, 1'b1, "R12 at 4th edge");
    chk(miso_oe, 1'b0, "R11 output enable end");

    wait_clk(8);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R5: actual=%0d pending expected=0", exp_q.size());
    end
    summary();
  end
endmodule